// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets a host processor reach the management registers of Ethernet PHYs over a two-wire MDC/MDIO bus using clause-22 frames. The host talks to it through a small 32-bit register window of six word registers. It loads a PHY and register address, then does one of two things. Writing a 16-bit value to the control register launches a write frame. Setting the command bit from 0 to 1 launches a read frame. The host then polls an indication register until the frame has ended. After a read, it fetches the returned value from the status register.

On the PHY side the block generates MDC from the system clock with a programmable divisor. It drives MDIO through an output and an output enable, and samples the MDIO input. MDC runs only while a frame is in flight and rests low otherwise. A soft-reset bit in the configuration register abandons any frame and puts the engine back to idle.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the configuration register (byte offset 0x00) reads 0x00000007 and the command (0x04), address (0x08), control (0x0C), status (0x10) and indication (0x14) registers read 0. MDC and the MDIO output enable are low.
- R2: The address register keeps only the PHY address in bits 12:8 and the register number in bits 4:0. All other bits read back as 0.
- R3: A control-register write while idle starts a write frame on the MDIO line, sent MSB first with the output enable high throughout. The frame is 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register number, turnaround 10 and the 16 data bits from bus_wdata[15:0]. The control register then reads back that value.
- R4: A read frame starts only when a write to the command register sets bit 0 while the stored bit 0 is 0. Writing 1 to an already-set bit starts nothing.
- R5: A read frame sends preamble, start 01, opcode 10, PHY and register address. It then releases the output enable for the 2 turnaround bits and the 16 data bits. It samples MDIO on each rising MDC edge. The 16 sampled bits, MSB first, appear in status bits 15:0 when the frame ends.
- R6: Indication bit 0 (busy) is 1 from the cycle after a frame is accepted until the frame's last MDC falling edge. It is 0 otherwise.
- R7: Indication bit 2 (not-valid) becomes 1 when a read is accepted. It returns to 0 in the same cycle that the read data lands in the status register. Write frames leave it at 0.
- R8: Configuration bits 2:0 select an MDC half period of 4, 4, 6, 8, 10, 14, 20 or 28 system clocks for the codes 0 to 7. MDC is low whenever no frame runs. The MDIO output changes only while MDC is low.
- R9: Writing configuration bit 31 as 1 ends any frame. By the following cycle, busy, not-valid, MDC and the output enable are all 0. No frame can start while the bit stays 1.
- R10: While busy, a control write changes neither the frame on the line nor the control register. A command 0-to-1 edge starts no read, but the command bit is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Byte address inside the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, 1 = master drives |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
A PHY model in the bench records every bit seen on the line together with the output enable. It answers reads with a value built from the addressed PHY and register. Write frames are applied with all-ones, all-zeros and alternating data at edge PHY and register addresses, which separates bit ordering faults from field placement faults. Read frames at several addresses show whether turnaround release, sampling edge and capture order are right. Extra starts issued mid-frame, a repeated command bit, and a soft reset in the middle of a read show whether the start qualification and the abort path hold the engine in a sane state.

// File: rtl/mdm_pkg.sv
// Package: shared constants, request type and divisor decode for the
// MDIO management master. Assumes clause-22 framing with 5-bit fields.
package mdm_pkg;

    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int MDATA_W = 16;
    localparam int SEL_W  = 3;
    localparam int HALF_W = 5;

    // Word indices of the register window (byte offset / 4)
    localparam int WIX_CFG  = 0;
    localparam int WIX_CMD  = 1;
    localparam int WIX_ADDR = 2;
    localparam int WIX_CTRL = 3;
    localparam int WIX_STAT = 4;
    localparam int WIX_IND  = 5;

    typedef struct packed {
        logic               rd;
        logic [PHY_W-1:0]   phy;
        logic [REG_W-1:0]   regad;
        logic [MDATA_W-1:0] wdata;
    } mdm_req_t;

    // Half MDC period in system clocks for a divisor select code
    function automatic logic [HALF_W-1:0] half_period(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 5'd4;
            3'd1:    return 5'd4;
            3'd2:    return 5'd6;
            3'd3:    return 5'd8;
            3'd4:    return 5'd10;
            3'd5:    return 5'd14;
            3'd6:    return 5'd20;
            default: return 5'd28;
        endcase
    endfunction

endpackage

// File: rtl/mdm_regs.sv
// Register window: six word registers, start qualification and the
// not-valid / read-data capture. Assumes single-cycle bus accesses and
// combinational read data.
module mdm_regs
    import mdm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy_i,
    input  logic              rd_done_i,
    input  logic [MDATA_W-1:0] rd_value_i,
    output logic              start_o,
    output mdm_req_t          req_o,
    output logic [SEL_W-1:0]  div_sel_o,
    output logic              soft_rst_o
);

    localparam int WIX_W = ADDR_W - 2;

    logic [WIX_W-1:0]   wix;
    logic               wr_hit;
    logic               soft_rst_q;
    logic [SEL_W-1:0]   div_sel_q;
    logic               cmd_q;
    logic [PHY_W-1:0]   phy_q;
    logic [REG_W-1:0]   reg_q;
    logic [MDATA_W-1:0] ctrl_q;
    logic [MDATA_W-1:0] status_q;
    logic               nv_q;
    logic               wr_start;
    logic               rd_start;
    logic               unused_bits;

    assign wix    = bus_addr[ADDR_W-1:2];
    assign wr_hit = bus_sel && bus_we;

    // Start qualification: idle engine, no soft reset held
    assign wr_start = wr_hit && (wix == WIX_W'(WIX_CTRL)) && !busy_i && !soft_rst_q;
    assign rd_start = wr_hit && (wix == WIX_W'(WIX_CMD)) && bus_wdata[0] && !cmd_q
                      && !busy_i && !soft_rst_q;

    assign start_o      = wr_start || rd_start;
    assign req_o.rd     = rd_start;
    assign req_o.phy    = phy_q;
    assign req_o.regad  = reg_q;
    assign req_o.wdata  = bus_wdata[MDATA_W-1:0];
    assign div_sel_o    = div_sel_q;
    assign soft_rst_o   = soft_rst_q;

    // Configuration register: soft reset bit and divisor select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_rst_q <= 1'b0;
            div_sel_q  <= '1;
        end else if (wr_hit && wix == WIX_W'(WIX_CFG)) begin
            soft_rst_q <= bus_wdata[DATA_W-1];
            div_sel_q  <= bus_wdata[SEL_W-1:0];
        end
    end

    // Command bit, stored even while busy so edges stay well defined
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= 1'b0;
        else if (wr_hit && wix == WIX_W'(WIX_CMD))
            cmd_q <= bus_wdata[0];
    end

    // Address register: PHY and register number fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q <= '0;
            reg_q <= '0;
        end else if (wr_hit && wix == WIX_W'(WIX_ADDR)) begin
            phy_q <= bus_wdata[8 +: PHY_W];
            reg_q <= bus_wdata[0 +: REG_W];
        end
    end

    // Control register keeps only writes that launched a frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_start)
            ctrl_q <= bus_wdata[MDATA_W-1:0];
    end

    // Status register captures the read result at frame end
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (rd_done_i)
            status_q <= rd_value_i;
    end

    // Not-valid flag: set on read launch, cleared on capture or abort
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_q)
            nv_q <= 1'b0;
        else if (rd_start)
            nv_q <= 1'b1;
        else if (rd_done_i)
            nv_q <= 1'b0;
    end

    // Read-back multiplexer
    always_comb begin
        bus_rdata = '0;
        case (wix)
            WIX_W'(WIX_CFG): begin
                bus_rdata[DATA_W-1]  = soft_rst_q;
                bus_rdata[SEL_W-1:0] = div_sel_q;
            end
            WIX_W'(WIX_CMD):  bus_rdata[0] = cmd_q;
            WIX_W'(WIX_ADDR): begin
                bus_rdata[8 +: PHY_W] = phy_q;
                bus_rdata[0 +: REG_W] = reg_q;
            end
            WIX_W'(WIX_CTRL): bus_rdata[MDATA_W-1:0] = ctrl_q;
            WIX_W'(WIX_STAT): bus_rdata[MDATA_W-1:0] = status_q;
            WIX_W'(WIX_IND): begin
                bus_rdata[0] = busy_i;
                bus_rdata[2] = nv_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-2:MDATA_W]};

    AST_NV_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> (nv_q && busy_i)); // R7

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done_i |=> $stable(status_q)); // R5

endmodule

// File: rtl/mdm_mdc_gen.sv
// MDC generator: divides the system clock by a programmable half period
// while run is high; idles low otherwise. Emits one-cycle ticks on the
// system-clock edge where MDC rises or falls.
module mdm_mdc_gen
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              mdc_o,
    output logic              rise_tick_o,
    output logic              fall_tick_o
);

    logic [HALF_W-1:0] cnt_q;
    logic              mdc_q;
    logic              wrap;

    assign wrap        = run_i && (cnt_q == half_i - HALF_W'(1));
    assign rise_tick_o = wrap && !mdc_q;
    assign fall_tick_o = wrap && mdc_q;
    assign mdc_o       = mdc_q;

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end

endmodule

// File: rtl/mdm_frame.sv
// Frame engine: serialises one clause-22 frame MSB first, shifting on MDC
// falling ticks and sampling read data on rising ticks. Assumes the
// request is presented with a single-cycle start while idle.
module mdm_frame
    import mdm_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort_i,
    input  logic               start_i,
    input  mdm_req_t           req_i,
    input  logic               rise_tick_i,
    input  logic               fall_tick_i,
    input  logic               mdc_i,
    input  logic               mdio_i,
    output logic               busy_o,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               rd_done_o,
    output logic [MDATA_W-1:0] rd_value_o
);

    localparam int FRAME_BITS = PRE_LEN + 4 + PHY_W + REG_W + 2 + MDATA_W;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int TA_POS     = PRE_LEN + 4 + PHY_W + REG_W;
    localparam int DAT_POS    = TA_POS + 2;
    localparam int LAST_POS   = FRAME_BITS - 1;

    logic                  busy_q;
    logic                  rd_q;
    logic [BIT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic [MDATA_W-1:0]    cap_q;
    logic                  last_bit;

    // Build the full serial word for a request
    function automatic logic [FRAME_BITS-1:0] frame_word(input mdm_req_t r);
        return {{PRE_LEN{1'b1}}, 2'b01,
                (r.rd ? 2'b10 : 2'b01),
                r.phy, r.regad,
                (r.rd ? 2'b11 : 2'b10),
                (r.rd ? {MDATA_W{1'b1}} : r.wdata)};
    endfunction

    assign last_bit   = (bit_cnt == BIT_W'(LAST_POS));
    assign busy_o     = busy_q;
    assign mdio_o     = busy_q && shreg[FRAME_BITS-1];
    assign mdio_oe    = busy_q && !(rd_q && bit_cnt >= BIT_W'(TA_POS));
    assign rd_done_o  = busy_q && rd_q && fall_tick_i && last_bit && !abort_i;
    assign rd_value_o = cap_q;

    // Frame sequencing: load, shift on falling ticks, end after last bit
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) begin
            busy_q  <= 1'b0;
            rd_q    <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q  <= 1'b1;
                rd_q    <= req_i.rd;
                bit_cnt <= '0;
                shreg   <= frame_word(req_i);
            end
        end else if (fall_tick_i) begin
            if (last_bit) begin
                busy_q <= 1'b0;
                rd_q   <= 1'b0;
            end else begin
                bit_cnt <= bit_cnt + BIT_W'(1);
                shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // Read data capture on MDC rising ticks during the data field
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= '0;
        else if (busy_q && rd_q && rise_tick_i && bit_cnt >= BIT_W'(DAT_POS))
            cap_q <= {cap_q[MDATA_W-2:0], mdio_i};
    end

    AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_i && $past(mdc_i)) |-> $stable(mdio_o)); // R8

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |=> !busy_q); // R6

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fall_tick_i && !abort_i) |=> $stable(bit_cnt)); // R3

endmodule

// File: rtl/mdio_mgmt_master.sv
// Top: register-mapped clause-22 MDIO management master. Connects the
// register window, the MDC generator and the frame engine. Assumes a
// synchronous single-cycle register bus and an external MDIO pull-up.
module mdio_mgmt_master
    import mdm_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic               busy;
    logic               rd_done;
    logic [MDATA_W-1:0] rd_value;
    logic               start;
    mdm_req_t           req;
    logic [SEL_W-1:0]   div_sel;
    logic               soft_rst;
    logic               rise_tick;
    logic               fall_tick;

    mdm_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy_i     (busy),
        .rd_done_i  (rd_done),
        .rd_value_i (rd_value),
        .start_o    (start),
        .req_o      (req),
        .div_sel_o  (div_sel),
        .soft_rst_o (soft_rst)
    );

    mdm_mdc_gen u_mdc (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (busy && !soft_rst),
        .half_i      (half_period(div_sel)),
        .mdc_o       (mdc),
        .rise_tick_o (rise_tick),
        .fall_tick_o (fall_tick)
    );

    mdm_frame #(
        .PRE_LEN (PRE_LEN)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort_i     (soft_rst),
        .start_i     (start),
        .req_i       (req),
        .rise_tick_i (rise_tick),
        .fall_tick_i (fall_tick),
        .mdc_i       (mdc),
        .mdio_i      (mdio_i),
        .busy_o      (busy),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .rd_done_o   (rd_done),
        .rd_value_o  (rd_value)
    );

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && !mdc && !mdio_oe)); // R9

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R8

endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_CFG  = 5'h00;
    localparam logic [4:0] A_CMD  = 5'h04;
    localparam logic [4:0] A_ADDR = 5'h08;
    localparam logic [4:0] A_CTRL = 5'h0C;
    localparam logic [4:0] A_STAT = 5'h10;
    localparam logic [4:0] A_IND  = 5'h14;

    typedef struct {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 0;
    exp_t exp_q[$];

    int          bit_n = 0;
    logic [63:0] fbits = '0;
    logic [63:0] obits = '0;
    logic [1:0]  mon_op = '0;
    logic [4:0]  mon_phy = '0;
    logic [4:0]  mon_reg = '0;

    mdio_mgmt_master dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
        return {3'b101, p, 3'b010, r};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            bus_read(A_IND, v);
            if (!v[0]) return;
        end
    endtask

    // Driver: write frame, expected item pushed to the scoreboard
    task automatic mdio_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        exp_t e;
        e.rd = 1'b0; e.phy = p; e.rg = r; e.data = d;
        bus_write(A_ADDR, {19'd0, p, 3'd0, r});
        exp_q.push_back(e);
        bus_write(A_CTRL, {16'd0, d});
    endtask

    // Driver: read frame via command bit clear then set
    task automatic mdio_read(input logic [4:0] p, input logic [4:0] r);
        exp_t e;
        e.rd = 1'b1; e.phy = p; e.rg = r; e.data = phy_val(p, r);
        bus_write(A_ADDR, {19'd0, p, 3'd0, r});
        bus_write(A_CMD, 32'd0);
        exp_q.push_back(e);
        bus_write(A_CMD, 32'd1);
    endtask

    // Monitor: collect line bits on MDC rise, compare whole frames
    initial begin
        forever begin
            @(posedge mdc);
            #1;
            fbits = {fbits[62:0], (mdio_oe ? mdio_o : mdio_i)};
            obits = {obits[62:0], mdio_oe};
            bit_n++;
            if (bit_n == 46) begin
                mon_op  = fbits[11:10];
                mon_phy = fbits[9:5];
                mon_reg = fbits[4:0];
            end
            if (bit_n == 64) begin
                exp_t e;
                logic [63:0] exp_line;
                logic [63:0] exp_oe;
                bit_n = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected frame", fbits, 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    exp_line = {32'hFFFF_FFFF, 2'b01, (e.rd ? 2'b10 : 2'b01),
                                e.phy, e.rg, 2'b10, e.data};
                    exp_oe = e.rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
                    check(fbits == exp_line, e.rd ? "R5 read frame line" : "R3 write frame line",
                          fbits, exp_line);
                    check(obits == exp_oe, e.rd ? "R5 read frame enable" : "R3 write frame enable",
                          obits, exp_oe);
                end
            end
        end
    end

    // PHY model: drives turnaround and read data after MDC falls
    initial begin
        forever begin
            @(negedge mdc);
            #1;
            if (mon_op == 2'b10 && bit_n == 46)
                mdio_i = 1'b1;
            else if (mon_op == 2'b10 && bit_n == 47)
                mdio_i = 1'b0;
            else if (mon_op == 2'b10 && bit_n >= 48 && bit_n <= 63) begin
                logic [15:0] pv;
                pv = phy_val(mon_phy, mon_reg);
                mdio_i = pv[63 - bit_n];
            end else
                mdio_i = 1'b1;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int          n;
        int          halves[4] = '{4, 6, 14, 28};
        int          sels[4]   = '{0, 2, 5, 7};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        bus_read(A_CFG, v);  check(v == 32'h7, "R1 cfg", v, 32'h7);
        bus_read(A_CMD, v);  check(v == 0, "R1 cmd", v, 0);
        bus_read(A_ADDR, v); check(v == 0, "R1 addr", v, 0);
        bus_read(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
        bus_read(A_STAT, v); check(v == 0, "R1 status", v, 0);
        bus_read(A_IND, v);  check(v == 0, "R1 indication", v, 0);
        check(mdc == 0 && mdio_oe == 0, "R1 pins", {mdc, mdio_oe}, 0);

        // R2 address field layout
        bus_write(A_ADDR, 32'hFFFF_FFFF);
        bus_read(A_ADDR, v); check(v == 32'h1F1F, "R2 addr readback", v, 32'h1F1F);

        bus_write(A_CFG, 32'd0);

        // R3 write frames with varied patterns, R6/R7 flags
        mdio_write(5'd1, 5'd2, 16'hFFFF);
        bus_read(A_IND, v); check(v == 32'h1, "R6 busy during write", v, 1);
        wait_idle();
        bus_read(A_IND, v); check(v == 0, "R6 busy cleared", v, 0);
        bus_read(A_CTRL, v); check(v == 32'hFFFF, "R3 ctrl readback", v, 32'hFFFF);
        mdio_write(5'd31, 5'd0, 16'h0000);
        wait_idle();
        mdio_write(5'd5, 5'd17, 16'hA55A);
        bus_read(A_IND, v); check(v == 32'h1, "R7 not-valid stays 0 on write", v, 1);
        wait_idle();

        // R5 read frames, R7 not-valid
        mdio_read(5'd0, 5'd1);
        bus_read(A_IND, v); check(v == 32'h5, "R7 busy and not-valid on read", v, 5);
        wait_idle();
        bus_read(A_IND, v); check(v == 0, "R7 not-valid cleared", v, 0);
        bus_read(A_STAT, v); check(v == {16'd0, phy_val(5'd0, 5'd1)}, "R5 status", v, phy_val(5'd0, 5'd1));
        mdio_read(5'd31, 5'd31);
        wait_idle();
        bus_read(A_STAT, v); check(v == {16'd0, phy_val(5'd31, 5'd31)}, "R5 status", v, phy_val(5'd31, 5'd31));
        mdio_read(5'd9, 5'd22);
        wait_idle();
        bus_read(A_STAT, v); check(v == {16'd0, phy_val(5'd9, 5'd22)}, "R5 status", v, phy_val(5'd9, 5'd22));

        // R4 command already set: writing 1 again starts nothing
        bus_write(A_CMD, 32'd1);
        bus_read(A_IND, v); check(v == 0, "R4 level no start", v, 0);
        n = 0;
        repeat (40) begin @(negedge clk); if (mdc) n++; end
        check(n == 0, "R4 mdc quiet", n, 0);

        // R10 requests while busy are ignored
        mdio_write(5'd3, 5'd4, 16'h1234);
        bus_write(A_CTRL, 32'h0000_BEEF);
        bus_write(A_CMD, 32'd0);
        bus_write(A_CMD, 32'd1);
        wait_idle();
        bus_read(A_CTRL, v); check(v == 32'h1234, "R10 ctrl unchanged", v, 32'h1234);
        bus_read(A_CMD, v);  check(v == 32'h1, "R10 cmd stored", v, 1);
        n = 0;
        repeat (60) begin @(negedge clk); if (mdc) n++; end
        bus_read(A_IND, v);
        check(n == 0 && v == 0, "R10 no extra frame", {n[31:0], v}, 0);

        // R8 divisor per select code
        for (int k = 0; k < 4; k++) begin
            bus_write(A_CFG, sels[k]);
            mdio_write(5'd7, 5'd8, 16'h00FF);
            @(posedge mdc);
            n = 0;
            do begin
                @(posedge clk); #1; n++;
            end while (mdc && n < 100);
            check(n == halves[k], "R8 half period", n, halves[k]);
            wait_idle();
        end

        // R9 soft reset during a read
        bus_write(A_CFG, 32'd2);
        mdio_read(5'd12, 5'd3);
        repeat (20) @(posedge mdc);
        bus_write(A_CFG, 32'h8000_0002);
        @(negedge clk);
        bus_read(A_IND, v);
        check(v == 0 && mdc == 0 && mdio_oe == 0, "R9 abort idle", {v, mdc, mdio_oe}, 0);
        bit_n = 0;
        mon_op = 2'b00;
        mdio_i = 1'b1;
        void'(exp_q.pop_front());
        bus_write(A_CTRL, 32'h0000_4321);
        bus_read(A_IND, v); check(v == 0, "R9 no start while held", v, 0);
        bus_write(A_CFG, 32'd2);
        mdio_read(5'd12, 5'd3);
        wait_idle();
        bus_read(A_STAT, v); check(v == {16'd0, phy_val(5'd12, 5'd3)}, "R9 recovery read", v, phy_val(5'd12, 5'd3));

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule